// File: doc/BRIEF.md
# Two-Port Byte-Lane Static Memory Core

This block is the storage core of a synchronous two-port static memory. A left and a right port each run on their own clock and can reach any word of the array, including the same word, at the same moment. Each port registers its address, write data and controls on its own rising edge. It decodes a pair of chip enables of opposite sense, an active-low write select and two active-low byte selects into per-lane write strobes and per-lane read requests. On the following edge of the same clock the port updates the array and samples its read word.

The bidirectional data pins of a packaged memory are split here into a write-data input and a raw read-data output per port. Each read output carries a two-bit lane-active flag, so that a separate output stage can decide which byte lanes to drive. The read path has no ready signal and applies no back-pressure: the downstream stage must take the word and flags in the cycle they appear. They stay stable until the next read of that port. Depth is set by `ADDR_W`. A 15-bit build gives 32K words and a 14-bit build gives 16K words. The default is kept small for quick elaboration.

Top module: `dpr_byte_ram`

## Requirements
- R1: A port whose first enable (`en0_*_n`) is high or whose second enable (`en1_*`) is low does nothing in that cycle: no lane is written, and its lane-active flags read 2'b00 for that command.
- R2: A port is selected only when `en0_*_n` is low and `en1_*` is high. A selected read with both byte selects low returns the full stored word.
- R3: A selected write (`wr_*_n` low) updates bits 15:8 only if `ub_*_n` is low and bits 7:0 only if `lb_*_n` is low. The other lane keeps its value. A write command raises no lane-active flag.
- R4: A selected command with both byte selects high writes nothing and raises no lane-active flag.
- R5: A selected read (`wr_*_n` high) sets flag bit 1 exactly when `ub_*_n` is low and flag bit 0 exactly when `lb_*_n` is low.
- R6: A port registers its inputs on its own rising edge, at edge k. Read word and flags for that command appear after edge k+1. A word written by a command captured at edge k is returned by any read captured at edge k+1 or later.
- R7: When one port writes a word and the other port reads the same word on the same edge, the reader returns the contents from before that write.
- R8: When both ports write the same byte lane of the same word on the same edge, the left port's data is stored. Writes to different lanes of one word on the same edge both take effect.
- R9: The read-data output of a port holds its value through every command that is not a read with at least one lane selected.
- R10: While a port's reset is low, its lane-active flags and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port asynchronous reset, active low |
| en0_l_n | input | 1 | Left first enable, active low |
| en1_l | input | 1 | Left second enable, active high |
| wr_l_n | input | 1 | Left write select, low writes, high reads |
| ub_l_n | input | 1 | Left upper-byte select, active low |
| lb_l_n | input | 1 | Left lower-byte select, active low |
| addr_l | input | ADDR_W | Left word address |
| din_l | input | DATA_W | Left write data |
| rdata_l | output | DATA_W | Left raw read word |
| rlane_l | output | 2 | Left read lane-active flags, bit 1 upper, bit 0 lower |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port asynchronous reset, active low |
| en0_r_n | input | 1 | Right first enable, active low |
| en1_r | input | 1 | Right second enable, active high |
| wr_r_n | input | 1 | Right write select, low writes, high reads |
| ub_r_n | input | 1 | Right upper-byte select, active low |
| lb_r_n | input | 1 | Right lower-byte select, active low |
| addr_r | input | ADDR_W | Right word address |
| din_r | input | DATA_W | Right write data |
| rdata_r | output | DATA_W | Right raw read word |
| rlane_r | output | 2 | Right read lane-active flags, bit 1 upper, bit 0 lower |

## Verification
The properties assume that each port's controls are valid, non-X levels at every rising edge of that port's clock once its reset is released. They also assume that a port's controls take effect two edges later on that same clock. The same-edge rules for reads and writes (R7, R8) further assume that the two clocks share their rising edges. The stimulus meets both conditions. It drives every input away from the clock edge from the first instant, and it runs both ports from one clock source. The random phase draws addresses from a handful of words so that collisions between the ports happen often.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANES = 2;

  // Byte selects are active low; bit 1 is the upper lane.
  function automatic logic [LANES-1:0] lane_pick(input logic ub_n, input logic lb_n);
    return {~ub_n, ~lb_n};
  endfunction

  function automatic logic port_on(input logic en0_n, input logic en1);
    return (!en0_n) && en1;
  endfunction
endpackage

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en0_n,
  input  logic                        en1,
  input  logic                        wr_n,
  input  logic                        ub_n,
  input  logic                        lb_n,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               din_i,
  input  logic [DW-1:0]               word_i,
  output logic [AW-1:0]               req_addr,
  output logic [DW-1:0]               req_data,
  output logic [dpr_pkg::LANES-1:0]   req_we,
  output logic [DW-1:0]               rd_word,
  output logic [dpr_pkg::LANES-1:0]   rd_act
);
  import dpr_pkg::*;

  logic [LANES-1:0] req_re;
  logic [LANES-1:0] lanes;
  logic             sel;

  always_comb begin
    lanes = lane_pick(ub_n, lb_n);
    sel   = port_on(en0_n, en1);
  end

  // Stage 1: input capture and decode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
      req_we   <= '0;
      req_re   <= '0;
    end else begin
      req_addr <= addr_i;
      req_data <= din_i;
      req_we   <= (sel && !wr_n) ? lanes : '0;
      req_re   <= (sel &&  wr_n) ? lanes : '0;
    end
  end

  // Stage 2: read sample, same edge as the array update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
      rd_act  <= '0;
    end else begin
      rd_act <= req_re;
      if (|req_re) rd_word <= word_i;
    end
  end
endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                        clk,
  input  logic [dpr_pkg::LANES-1:0]   we,
  input  logic [AW-1:0]               waddr,
  input  logic [DW-1:0]               wdata,
  input  logic [DW-1:0]               partner,
  output logic [DW-1:0]               own_q,
  input  logic [AW-1:0]               peek_addr,
  output logic [DW-1:0]               peek_q
);
  import dpr_pkg::*;
  localparam int DEPTH  = 1 << AW;
  localparam int LANE_W = DW / LANES;

  logic [DW-1:0] mem [DEPTH];

  assign own_q  = mem[waddr];
  assign peek_q = mem[peek_addr];

  // Stored value is the data XOR the partner bank, so that the
  // logical word is always the XOR of the two banks.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i])
        mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W] ^ partner[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/dpr_byte_ram.sv
module dpr_byte_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_l,
  input  logic              rst_l_n,
  input  logic              en0_l_n,
  input  logic              en1_l,
  input  logic              wr_l_n,
  input  logic              ub_l_n,
  input  logic              lb_l_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] rdata_l,
  output logic [1:0]        rlane_l,
  input  logic              clk_r,
  input  logic              rst_r_n,
  input  logic              en0_r_n,
  input  logic              en1_r,
  input  logic              wr_r_n,
  input  logic              ub_r_n,
  input  logic              lb_r_n,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] rdata_r,
  output logic [1:0]        rlane_r
);
  import dpr_pkg::*;

  logic [ADDR_W-1:0] qa_l, qa_r;
  logic [DATA_W-1:0] qd_l, qd_r;
  logic [LANES-1:0]  we_l, we_r, we_r_eff, yield;
  logic [DATA_W-1:0] own_l, own_r, peek_r_at_l, peek_l_at_r;
  logic [DATA_W-1:0] word_l, word_r;

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_l (
    .clk(clk_l), .rst_n(rst_l_n), .en0_n(en0_l_n), .en1(en1_l), .wr_n(wr_l_n),
    .ub_n(ub_l_n), .lb_n(lb_l_n), .addr_i(addr_l), .din_i(din_l), .word_i(word_l),
    .req_addr(qa_l), .req_data(qd_l), .req_we(we_l), .rd_word(rdata_l), .rd_act(rlane_l)
  );

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_r (
    .clk(clk_r), .rst_n(rst_r_n), .en0_n(en0_r_n), .en1(en1_r), .wr_n(wr_r_n),
    .ub_n(ub_r_n), .lb_n(lb_r_n), .addr_i(addr_r), .din_i(din_r), .word_i(word_r),
    .req_addr(qa_r), .req_data(qd_r), .req_we(we_r), .rd_word(rdata_r), .rd_act(rlane_r)
  );

  // Right port drops any lane the left port is about to write in the same word.
  always_comb begin
    yield    = (qa_l == qa_r) ? we_l : '0;
    we_r_eff = we_r & ~yield;
    word_l   = own_l ^ peek_r_at_l;
    word_r   = own_r ^ peek_l_at_r;
  end

  dpr_xor_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank_l (
    .clk(clk_l), .we(we_l), .waddr(qa_l), .wdata(qd_l), .partner(peek_r_at_l),
    .own_q(own_l), .peek_addr(qa_r), .peek_q(peek_l_at_r)
  );

  dpr_xor_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank_r (
    .clk(clk_r), .we(we_r_eff), .waddr(qa_r), .wdata(qd_r), .partner(peek_l_at_r),
    .own_q(own_r), .peek_addr(qa_l), .peek_q(peek_r_at_l)
  );
endmodule

// File: rtl/dpr_byte_ram_chk.sv
module dpr_byte_ram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk_l,
  input logic              rst_l_n,
  input logic              en0_l_n,
  input logic              en1_l,
  input logic              wr_l_n,
  input logic              ub_l_n,
  input logic              lb_l_n,
  input logic [DATA_W-1:0] rdata_l,
  input logic [1:0]        rlane_l,
  input logic              clk_r,
  input logic              rst_r_n,
  input logic              en0_r_n,
  input logic              en1_r,
  input logic              wr_r_n,
  input logic              ub_r_n,
  input logic              lb_r_n,
  input logic [DATA_W-1:0] rdata_r,
  input logic [1:0]        rlane_r
);
  // R1
  desel_l_chk: assert property (@(posedge clk_l) disable iff (!rst_l_n)
    (en0_l_n || !en1_l) |-> ##2 (rlane_l == 2'b00));
  // R1
  desel_r_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (en0_r_n || !en1_r) |-> ##2 (rlane_r == 2'b00));
  // R3
  wr_noflag_l_chk: assert property (@(posedge clk_l) disable iff (!rst_l_n)
    (!en0_l_n && en1_l && !wr_l_n) |-> ##2 (rlane_l == 2'b00));
  // R4
  nolane_r_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (ub_r_n && lb_r_n) |-> ##2 (rlane_r == 2'b00));
  // R5
  upper_l_chk: assert property (@(posedge clk_l) disable iff (!rst_l_n)
    ub_l_n |-> ##2 !rlane_l[1]);
  // R5
  lower_r_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    lb_r_n |-> ##2 !rlane_r[0]);
  // R5
  full_rd_l_chk: assert property (@(posedge clk_l) disable iff (!rst_l_n)
    (!en0_l_n && en1_l && wr_l_n && !ub_l_n && !lb_l_n) |-> ##2 (rlane_l == 2'b11));
  // R9
  hold_l_chk: assert property (@(posedge clk_l) disable iff (!rst_l_n)
    !(!en0_l_n && en1_l && wr_l_n && (!ub_l_n || !lb_l_n)) |-> ##2 $stable(rdata_l));
  // R9
  hold_r_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    !(!en0_r_n && en1_r && wr_r_n && (!ub_r_n || !lb_r_n)) |-> ##2 $stable(rdata_r));
endmodule

bind dpr_byte_ram dpr_byte_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_l(clk_l), .rst_l_n(rst_l_n), .en0_l_n(en0_l_n), .en1_l(en1_l), .wr_l_n(wr_l_n),
  .ub_l_n(ub_l_n), .lb_l_n(lb_l_n), .rdata_l(rdata_l), .rlane_l(rlane_l),
  .clk_r(clk_r), .rst_r_n(rst_r_n), .en0_r_n(en0_r_n), .en1_r(en1_r), .wr_r_n(wr_r_n),
  .ub_r_n(ub_r_n), .lb_r_n(lb_r_n), .rdata_r(rdata_r), .rlane_r(rlane_r)
);

// File: tb/sim_dpr_byte_ram.sv
module sim_dpr_byte_ram;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    bit          e0n, e1, wrn, ubn, lbn;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en0_l_n, en1_l, wr_l_n, ub_l_n, lb_l_n, en0_r_n, en1_r, wr_r_n, ub_r_n, lb_r_n;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] din_l, din_r, rdata_l, rdata_r;
  logic [1:0]    rlane_l, rlane_r;

  int errors = 0, checks = 0, collisions = 0;
  bit finished = 0;
  string dtag = "";

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_l = '0, exp_r = '0;
  cmd_t pend_l, pend_r, cur_l, cur_r;

  always #10 clk = ~clk;

  dpr_byte_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_l(clk), .rst_l_n(rst_n), .en0_l_n(en0_l_n), .en1_l(en1_l), .wr_l_n(wr_l_n),
    .ub_l_n(ub_l_n), .lb_l_n(lb_l_n), .addr_l(addr_l), .din_l(din_l),
    .rdata_l(rdata_l), .rlane_l(rlane_l),
    .clk_r(clk), .rst_r_n(rst_n), .en0_r_n(en0_r_n), .en1_r(en1_r), .wr_r_n(wr_r_n),
    .ub_r_n(ub_r_n), .lb_r_n(lb_r_n), .addr_r(addr_r), .din_r(din_r),
    .rdata_r(rdata_r), .rlane_r(rlane_r)
  );

  function automatic cmd_t mk(bit e0n, bit e1, bit wrn, bit ubn, bit lbn, int a, logic [DW-1:0] d);
    cmd_t c;
    c.e0n = e0n; c.e1 = e1; c.wrn = wrn; c.ubn = ubn; c.lbn = lbn;
    c.a = AW'(a); c.d = d;
    return c;
  endfunction

  function automatic cmd_t idle();
    return mk(1, 0, 1, 1, 1, 0, '0);
  endfunction

  function automatic logic [1:0] f_we(cmd_t c);
    if (!c.e0n && c.e1 && !c.wrn) return {~c.ubn, ~c.lbn};
    return 2'b00;
  endfunction

  function automatic logic [1:0] f_re(cmd_t c);
    if (!c.e0n && c.e1 && c.wrn) return {~c.ubn, ~c.lbn};
    return 2'b00;
  endfunction

  function automatic string act_tag(cmd_t c);
    if (c.e0n || !c.e1) return "R1";
    if (c.ubn && c.lbn) return "R4";
    if (!c.wrn) return "R3";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive();
    en0_l_n = cur_l.e0n; en1_l = cur_l.e1; wr_l_n = cur_l.wrn; ub_l_n = cur_l.ubn;
    lb_l_n = cur_l.lbn; addr_l = cur_l.a; din_l = cur_l.d;
    en0_r_n = cur_r.e0n; en1_r = cur_r.e1; wr_r_n = cur_r.wrn; ub_r_n = cur_r.ubn;
    lb_r_n = cur_r.lbn; addr_r = cur_r.a; din_r = cur_r.d;
  endtask

  // One cycle: check results of the command executed at the edge just passed,
  // apply its writes to the model, then advance the pipeline and drive new inputs.
  task automatic tick(cmd_t nl, cmd_t nr);
    logic [1:0] wl, wr;
    string t;
    @(negedge clk);
    chk({act_tag(pend_l), " left flags"}, DW'(rlane_l), DW'(f_re(pend_l)));
    chk({act_tag(pend_r), " right flags"}, DW'(rlane_r), DW'(f_re(pend_r)));
    wl = f_we(pend_l); wr = f_we(pend_r);
    if (|f_re(pend_l)) begin
      exp_l = ref_mem[pend_l.a];
      t = (dtag != "") ? dtag : ((|wr && pend_r.a == pend_l.a) ? "R7" : "R2");
      chk({t, " left data"}, rdata_l, exp_l);
    end else chk("R9 left hold", rdata_l, exp_l);
    if (|f_re(pend_r)) begin
      exp_r = ref_mem[pend_r.a];
      t = (dtag != "") ? dtag : ((|wl && pend_r.a == pend_l.a) ? "R7" : "R2");
      chk({t, " right data"}, rdata_r, exp_r);
    end else chk("R9 right hold", rdata_r, exp_r);
    if (pend_l.a == pend_r.a && |(wl & wr)) collisions++;
    if (wr[1]) ref_mem[pend_r.a][15:8] = pend_r.d[15:8];
    if (wr[0]) ref_mem[pend_r.a][7:0]  = pend_r.d[7:0];
    if (wl[1]) ref_mem[pend_l.a][15:8] = pend_l.d[15:8];
    if (wl[0]) ref_mem[pend_l.a][7:0]  = pend_l.d[7:0];
    pend_l = cur_l; pend_r = cur_r;
    cur_l = nl; cur_r = nr;
    drive();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("collisions seen: %0d", collisions);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    pend_l = idle(); pend_r = idle(); cur_l = idle(); cur_r = idle();
    drive();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 left flags", DW'(rlane_l), '0);
    chk("R10 left data", rdata_l, '0);
    chk("R10 right flags", DW'(rlane_r), '0);
    chk("R10 right data", rdata_r, '0);
    rst_n = 1'b1;

    // Preload every word through the left port.
    for (int a = 0; a < DEPTH; a++)
      tick(mk(0, 1, 0, 0, 0, a, DW'(a * 16'h9E37 + 16'h1234)), idle());

    // R6: write then read next cycle on the other port sees new data
    dtag = "R6";
    tick(mk(0, 1, 0, 0, 0, 3, 16'hBEEF), idle());
    tick(idle(), mk(0, 1, 1, 0, 0, 3, '0));
    tick(idle(), idle()); tick(idle(), idle()); tick(idle(), idle());
    chk("R6 right literal", rdata_r, 16'hBEEF);

    // R1 deselect by either enable: writes must not land
    dtag = "R1";
    tick(mk(1, 1, 0, 0, 0, 3, 16'h0000), mk(0, 0, 0, 0, 0, 3, 16'hFFFF));
    tick(idle(), idle());
    tick(mk(0, 1, 1, 0, 0, 3, '0), idle());
    tick(idle(), idle()); tick(idle(), idle());
    chk("R1 left literal", rdata_l, 16'hBEEF);

    // R3 single-lane writes, R4 both selects high
    dtag = "R3";
    tick(mk(0, 1, 0, 0, 1, 3, 16'h11AA), idle());
    tick(mk(0, 1, 0, 1, 0, 3, 16'h22CC), mk(0, 1, 0, 1, 1, 3, 16'h5555));
    tick(idle(), idle());
    tick(mk(0, 1, 1, 0, 0, 3, '0), idle());
    tick(idle(), idle()); tick(idle(), idle());
    chk("R3 left literal", rdata_l, 16'h11CC);

    // R7 same-edge write and read: reader sees old word
    dtag = "R7";
    tick(mk(0, 1, 0, 0, 0, 3, 16'h7777), mk(0, 1, 1, 0, 0, 3, '0));
    tick(idle(), idle()); tick(idle(), idle());
    chk("R7 right literal", rdata_r, 16'h11CC);

    // R8 both write: same lane left wins, other lane merges
    dtag = "R8";
    tick(mk(0, 1, 0, 0, 1, 9, 16'h5A00), mk(0, 1, 0, 0, 0, 9, 16'hA53C));
    tick(idle(), idle());
    tick(mk(0, 1, 1, 0, 0, 9, '0), idle());
    tick(idle(), idle()); tick(idle(), idle());
    chk("R8 left literal", rdata_l, 16'h5A3C);

    // R5 lane flags: upper only, then lower only (checked inside tick)
    dtag = "R5";
    tick(mk(0, 1, 1, 0, 1, 9, '0), mk(0, 1, 1, 1, 0, 9, '0));
    tick(idle(), idle()); tick(idle(), idle());
    dtag = "";

    // Constrained random on a small address window.
    for (int n = 0; n < 4000; n++) begin
      cmd_t cl, cr;
      cl = mk(($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 4) == 0,
              ($urandom % 4) == 0, $urandom % 8, DW'($urandom));
      cr = mk(($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 4) == 0,
              ($urandom % 4) == 0, $urandom % 8, DW'($urandom));
      tick(cl, cr);
    end
    tick(idle(), idle()); tick(idle(), idle());
    finish_run();
  end
endmodule